// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block keeps the decoded micro-ops of recently decoded instructions, indexed by the fetch address of each instruction. The fetch stage presents every address to the lookup port before decode starts. On a hit, the block returns the stored micro-ops one cycle later and raises `dec_sleep`. That output powers the decoder down for the cycle in which the cache alone feeds the pipeline. On a miss the decoder runs, and every instruction it emits comes back on the fill port. Each fill is stored as one entry for that single instruction. There is no selection policy, and sequences that cross taken branches are never stored as traces.

The array is direct mapped. The entry index is the full byte address taken modulo the entry count. The entry count is the total micro-op capacity (default 1536) divided by the slots per entry (default 4), which gives 384 entries. Each entry stores the complete instruction address, a micro-op count and its micro-op slots. The cache must never hold an instruction whose line has left the instruction cache. To keep that rule, an invalidate port names an evicted line, and every entry whose address falls inside that line is cleared in the same cycle. A flush input clears the whole array. Two counters give the running totals of hit and miss responses.

Top module: `uop_cache`

## Requirements
- R1: Every cycle with `lk_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge. `rsp_valid` is low in every other cycle.
- R2: A lookup of an address whose stored entry is valid returns `dec_sleep`=1. It also returns `rsp_cnt` equal to the stored count, and `rsp_uops` with slot k (bits k*32 up to k*32+31) equal to the filled slot k for every k below the count and zero for every other slot.
- R3: A lookup that misses returns `rsp_valid`=1 with `dec_sleep`=0, `rsp_cnt`=0 and `rsp_uops` all zero.
- R4: The entry index is the address modulo 384 (default). A fill replaces whatever that index held, so a previously stored address with the same index then misses.
- R5: A fill whose `fill_cnt` is 0 or greater than 4 (the slots per entry) is ignored, and the entry already at that index keeps its contents.
- R6: When a lookup and a fill address the same index in the same cycle, the lookup reports a miss and the fill is still stored.
- R7: An invalidate clears every entry whose address bits [31:6] equal `inv_line`, for 64-byte lines. Entries in other lines are kept.
- R8: A fill is dropped when its address lies in the line being invalidated in that cycle, or when its target entry is invalidated in that cycle.
- R9: `flush` clears every entry in one cycle, and a fill presented in the same cycle is dropped.
- R10: A lookup presented together with `flush`, or together with an invalidate of its own line, reports a miss.
- R11: `hit_cnt` increments once for each hit response and `miss_cnt` once for each miss response, wrapping at 16 bits.
- R12: After reset every entry is invalid, `rsp_valid` and `dec_sleep` are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address to look up |
| fill_valid | input | 1 | Decoded instruction presented for storage |
| fill_addr | input | 32 | Address of the decoded instruction |
| fill_cnt | input | 4 | Number of micro-ops the instruction decoded to |
| fill_uops | input | 128 | Micro-op slots, slot k in bits k*32 up to k*32+31 |
| inv_valid | input | 1 | Instruction-cache line eviction |
| inv_line | input | 26 | Evicted line address (address bits 31:6) |
| flush | input | 1 | Clear every entry |
| rsp_valid | output | 1 | Lookup result valid |
| dec_sleep | output | 1 | Hit: decoder powered down, cache supplies micro-ops |
| rsp_cnt | output | 4 | Micro-op count of the hit, zero on a miss |
| rsp_uops | output | 128 | Micro-ops of the hit, unused slots zero |
| hit_cnt | output | 16 | Running count of hit responses |
| miss_cnt | output | 16 | Running count of miss responses |

## Verification
Each lookup result is due on the clock edge after the lookup is presented. A fill, invalidate or flush presented in one cycle is visible to a lookup presented in the next cycle. Lookups that share a cycle with one of these see the pre-edge state, except that the collision and eviction cases of R6 and R10 force a miss. The counters change on the same edge as the response they tally. The bench drives every input on a falling edge and checks the registered outputs at the following falling edge. Each check therefore lands exactly one rising edge after its stimulus. The inputs are cleared at the same point, so no stimulus lasts longer than one cycle.

// File: rtl/uop_cache.sv
module uop_cache #(
  parameter int ADDR_W     = 32,
  parameter int UOP_W      = 32,
  parameter int SLOTS      = 4,
  parameter int TOTAL_UOPS = 1536,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 4,
  parameter int CTR_W      = 16,
  localparam int ENTRIES   = TOTAL_UOPS / SLOTS,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LOFF      = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LOFF,
  localparam int DATA_W    = SLOTS * UOP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic [DATA_W-1:0] fill_uops,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              dec_sleep,
  output logic [CNT_W-1:0]  rsp_cnt,
  output logic [DATA_W-1:0] rsp_uops,
  output logic [CTR_W-1:0]  hit_cnt,
  output logic [CTR_W-1:0]  miss_cnt
);

  localparam logic [ADDR_W-1:0] ENT_A  = ADDR_W'(ENTRIES);
  localparam logic [CNT_W-1:0]  SLOT_C = CNT_W'(SLOTS);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a % ENT_A);
  endfunction

  logic              vld   [ENTRIES];
  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_q [ENTRIES];
  logic [DATA_W-1:0] uop_q [ENTRIES];

  wire [IDX_W-1:0] fill_idx = idx_of(fill_addr);
  wire [IDX_W-1:0] lk_idx   = idx_of(lk_addr);

  wire fill_in_evict = inv_valid && (fill_addr[ADDR_W-1:LOFF] == inv_line);
  wire lk_in_evict   = inv_valid && (lk_addr[ADDR_W-1:LOFF] == inv_line);
  wire fill_size_ok  = (fill_cnt != '0) && (fill_cnt <= SLOT_C);
  wire fill_ok       = fill_valid && fill_size_ok && !flush && !fill_in_evict;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    wire kill = flush || (inv_valid && vld[e] && (tag_q[e][ADDR_W-1:LOFF] == inv_line));
    always_ff @(posedge clk) begin
      if (rst)                                          vld[e] <= 1'b0;
      else if (kill)                                    vld[e] <= 1'b0;
      else if (fill_ok && (fill_idx == IDX_W'(e)))      vld[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[fill_idx] <= fill_addr;
      cnt_q[fill_idx] <= fill_cnt;
      uop_q[fill_idx] <= fill_uops;
    end
  end

  wire collide = fill_valid && (fill_idx == lk_idx);
  wire hit = lk_valid && vld[lk_idx] && (tag_q[lk_idx] == lk_addr)
             && !flush && !lk_in_evict && !collide;

  wire [CNT_W-1:0] rd_cnt = cnt_q[lk_idx];
  logic [DATA_W-1:0] rd_uops;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign rd_uops[s*UOP_W +: UOP_W] =
      (hit && (CNT_W'(s) < rd_cnt)) ? uop_q[lk_idx][s*UOP_W +: UOP_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      dec_sleep <= 1'b0;
      rsp_cnt   <= '0;
      rsp_uops  <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      dec_sleep <= hit;
      rsp_cnt   <= hit ? rd_cnt : '0;
      rsp_uops  <= rd_uops;
      if (hit)                 hit_cnt  <= hit_cnt + 1'b1;
      if (lk_valid && !hit)    miss_cnt <= miss_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uop_cache_chk.sv
module uop_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int UOP_W      = 32,
  parameter int SLOTS      = 4,
  parameter int TOTAL_UOPS = 1536,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 4,
  parameter int CTR_W      = 16,
  localparam int ENTRIES   = TOTAL_UOPS / SLOTS,
  localparam int LOFF      = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LOFF,
  localparam int DATA_W    = SLOTS * UOP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line,
  input logic              flush,
  input logic              rsp_valid,
  input logic              dec_sleep,
  input logic [CNT_W-1:0]  rsp_cnt,
  input logic [DATA_W-1:0] rsp_uops,
  input logic [CTR_W-1:0]  hit_cnt,
  input logic [CTR_W-1:0]  miss_cnt
);

  localparam logic [ADDR_W-1:0] ENT_A = ADDR_W'(ENTRIES);
  wire same_idx = (lk_addr % ENT_A) == (fill_addr % ENT_A);

  AST_RSP_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R1
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid); // R1
  AST_SLEEP_ONLY_ON_RSP: assert property (@(posedge clk) disable iff (rst)
    dec_sleep |-> rsp_valid); // R2
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !dec_sleep) |-> (rsp_cnt == '0 && rsp_uops == '0)); // R3
  AST_HIT_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    dec_sleep |-> (rsp_cnt != '0 && rsp_cnt <= CNT_W'(SLOTS))); // R5
  AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && fill_valid && same_idx) |=> !dec_sleep); // R6
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && flush) |=> !dec_sleep); // R10
  AST_EVICT_MISS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && inv_valid && lk_addr[ADDR_W-1:LOFF] == inv_line) |=> !dec_sleep); // R10
  AST_HIT_TALLY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && dec_sleep) |-> hit_cnt == CTR_W'($past(hit_cnt) + 1'b1)); // R11
  AST_MISS_TALLY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !dec_sleep) |-> miss_cnt == CTR_W'($past(miss_cnt) + 1'b1)); // R11

endmodule

bind uop_cache uop_cache_chk #(
  .ADDR_W(ADDR_W), .UOP_W(UOP_W), .SLOTS(SLOTS), .TOTAL_UOPS(TOTAL_UOPS),
  .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W), .CTR_W(CTR_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .inv_valid(inv_valid),
  .inv_line(inv_line), .flush(flush), .rsp_valid(rsp_valid),
  .dec_sleep(dec_sleep), .rsp_cnt(rsp_cnt), .rsp_uops(rsp_uops),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/uop_cache_bench.sv
`timescale 1ns/1ps
module uop_cache_bench;
  localparam int AW = 32, UW = 32, SL = 4, CW = 4, TW = 16, LW = 26, DW = SL * UW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, fill_valid = 0, inv_valid = 0, flush = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [CW-1:0] fill_cnt = '0;
  logic [DW-1:0] fill_uops = '0;
  logic [LW-1:0] inv_line = '0;
  logic rsp_valid, dec_sleep;
  logic [CW-1:0] rsp_cnt;
  logic [DW-1:0] rsp_uops;
  logic [TW-1:0] hit_cnt, miss_cnt;

  int n_chk = 0, n_bad = 0, exp_hits = 0, exp_miss = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uop_cache u_uop_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_cnt(fill_cnt),
    .fill_uops(fill_uops), .inv_valid(inv_valid), .inv_line(inv_line),
    .flush(flush), .rsp_valid(rsp_valid), .dec_sleep(dec_sleep),
    .rsp_cnt(rsp_cnt), .rsp_uops(rsp_uops), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  function automatic logic [DW-1:0] mk(input logic [7:0] seed, input int c);
    logic [DW-1:0] v = '0;
    for (int k = 0; k < SL; k++)
      if (k < c) v[k*UW +: UW] = {seed, 24'(k + 1)};
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush = 0;
  endtask

  task automatic set_fill(input logic [AW-1:0] a, input int c, input logic [7:0] seed);
    fill_valid = 1; fill_addr = a; fill_cnt = CW'(c); fill_uops = mk(seed, SL);
  endtask

  task automatic expect_rsp(input string req, input bit eh, input int ec, input logic [7:0] es);
    check({req, " rsp_valid"}, DW'(rsp_valid), DW'(1));
    check({req, " dec_sleep"}, DW'(dec_sleep), DW'(eh));
    check({req, " rsp_cnt"},   DW'(rsp_cnt),   eh ? DW'(ec) : '0);
    check({req, " rsp_uops"},  rsp_uops,       eh ? mk(es, ec) : '0);
    if (eh) exp_hits++; else exp_miss++;
  endtask

  task automatic look(input string req, input logic [AW-1:0] a, input bit eh,
                      input int ec, input logic [7:0] es);
    lk_valid = 1; lk_addr = a;
    apply();
    expect_rsp(req, eh, ec, es);
  endtask

  // op 0 = fill, 1 = lookup
  localparam int NV = 12;
  localparam bit          V_OP  [NV] = '{1, 0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1};
  localparam logic [31:0] V_AD  [NV] = '{32'h1000, 32'h1000, 32'h1000, 32'h1004,
                                         32'h1004, 32'h1180, 32'h1000, 32'h1180,
                                         32'h1008, 32'h1008, 32'h1180, 32'h1180};
  localparam int          V_CNT [NV] = '{0, 3, 3, 1, 1, 4, 0, 4, 5, 0, 0, 4};
  localparam logic [7:0]  V_SD  [NV] = '{8'h00, 8'h11, 8'h11, 8'h22, 8'h22, 8'h33,
                                         8'h00, 8'h33, 8'h44, 8'h00, 8'h55, 8'h33};
  localparam bit          V_HIT [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 1};
  // rows: 0 R3 cold miss; 2 R2 hit; 4 R2 single uop; 5-7 R4 same index 256 replaces;
  // 8-9 R5 oversize fill; 10-11 R5 zero-count fill leaves entry intact

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 rsp_valid", DW'(rsp_valid), '0);
    check("R12 dec_sleep", DW'(dec_sleep), '0);
    check("R12 hit_cnt",   DW'(hit_cnt),   '0);
    check("R12 miss_cnt",  DW'(miss_cnt),  '0);

    for (int i = 0; i < NV; i++) begin
      if (!V_OP[i]) begin
        set_fill(V_AD[i], V_CNT[i], V_SD[i]);
        apply();
      end else begin
        look($sformatf("table[%0d]", i), V_AD[i], V_HIT[i], V_CNT[i], V_SD[i]);
      end
    end

    apply();
    check("R1 idle no rsp", DW'(rsp_valid), '0);

    // R6 same-index collision: miss now, stored afterwards
    set_fill(32'h3000, 2, 8'h66);
    look("R6 collide", 32'h3000, 0, 0, 8'h00);
    look("R6 fill kept", 32'h3000, 1, 2, 8'h66);

    // R7 line invalidate
    set_fill(32'h2000, 1, 8'h71); apply();
    set_fill(32'h2010, 2, 8'h72); apply();
    set_fill(32'h2040, 3, 8'h73); apply();
    inv_valid = 1; inv_line = LW'(32'h2000 >> 6); apply();
    look("R7 line lost a", 32'h2000, 0, 0, 8'h00);
    look("R7 line lost b", 32'h2010, 0, 0, 8'h00);
    look("R7 other line kept", 32'h2040, 1, 3, 8'h73);

    // R8 fill into evicting line dropped
    set_fill(32'h2020, 2, 8'h81);
    inv_valid = 1; inv_line = LW'(32'h2000 >> 6); apply();
    look("R8 fill dropped", 32'h2020, 0, 0, 8'h00);

    // R10 lookup with invalidate of its line
    set_fill(32'h2010, 2, 8'h82); apply();
    inv_valid = 1; inv_line = LW'(32'h2000 >> 6);
    look("R10 evict miss", 32'h2010, 0, 0, 8'h00);

    // R10 lookup with flush
    flush = 1;
    look("R10 flush miss", 32'h1004, 0, 0, 8'h00);

    // R9 flush clears all, concurrent fill dropped
    set_fill(32'h1004, 1, 8'h91); apply();
    set_fill(32'h5000, 2, 8'h92); flush = 1; apply();
    look("R9 flushed entry", 32'h1004, 0, 0, 8'h00);
    look("R9 fill with flush", 32'h5000, 0, 0, 8'h00);
    look("R9 old entry gone", 32'h3000, 0, 0, 8'h00);

    check("R11 hit_cnt",  DW'(hit_cnt),  DW'(exp_hits));
    check("R11 miss_cnt", DW'(miss_cnt), DW'(exp_miss));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule